// File: doc/BRIEF.md
# Rectangle Solid Color Fill Engine

The engine receives a six-word fill command over a simple valid/ready word stream. It paints one packed color value into every pixel of an axis-aligned rectangle in a linear (row-major, untiled) frame buffer. The rectangle is given by an inclusive near corner and an exclusive far corner. The engine walks it row by row and issues one word-addressed write with byte enables per pixel. Pixel depth is 1, 2 or 4 bytes. At 4 bytes per pixel the color bytes and the alpha byte are gated by two separate header flags.

Before any memory write, the engine validates the whole command: the length field, the raster operation, the depth code, the alignment and the size limits. A command that fails any of these checks completes with an error pulse and leaves memory untouched. A command whose rectangle is empty completes at once without writing and without an error.

Top module: `rect_fill_engine`

## Requirements
- R1: A command is six words taken in order: header, format word, near corner, far corner, destination byte address, color. Header bits 7:0 must hold 4 (word count minus two). Any other value rejects the command.
- R2: Each corner word carries y in bits 31:16 and x in bits 15:0. Every pixel with x1 <= x < x2 and y1 <= y < y2 is written exactly once, and nothing outside that rectangle is written.
- R3: A pixel's byte address is base + y*pitch + x*bpp. The port carries byte address bits ADDR_W+1:2 as the word address, and byte address bits 1:0 select the first lane. Writes go in row-major order with ascending x.
- R4: Format word bits 25:24 select the depth: 0 gives 1 byte, 1 gives 2 bytes, 3 gives 4 bytes. Code 2 rejects the command.
- R5: At 4 bytes per pixel, lanes 0..2 are enabled only when header bit 20 (color write) is set, and lane 3 only when header bit 21 (alpha write) is set. At 1 or 2 bytes per pixel both flags have no effect.
- R6: At 1 byte per pixel exactly one lane is enabled, holding color bits 7:0. At 2 bytes per pixel two adjacent lanes hold color bits 15:0, low byte first.
- R7: When (x2-x1)*bpp >= ROW_LIMIT or y2-y1 >= LINE_LIMIT, the command is rejected and no write is made.
- R8: The raster operation in format word bits 23:16 must be 0xF0 (write the color unchanged). Any other code, including 0xCC, rejects the command.
- R9: The base address and the pitch (format word bits 15:0) must both have their two low bits clear. Otherwise the command is rejected.
- R10: When x1 >= x2 or y1 >= y2 and no R1/R4/R8/R9 fault is present, the command completes without writes and without an error. Emptiness overrides the R7 limits.
- R11: busy is high from the cycle after the header is taken until the last write is acknowledged. done is then a one-cycle pulse with busy low. err is high only together with done, and only for a rejected command.
- R12: mem_req, once raised, stays high with mem_addr, mem_wdata and mem_be unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine takes a command word |
| cmd_data | input | 32 | Command word |
| mem_req | output | 1 | Write request |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit n for byte lane n |
| mem_ack | input | 1 | Write accepted in this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Command rejected (with done) |

## Verification
The bench builds the engine with ADDR_W=8, ROW_LIMIT=64 and LINE_LIMIT=8. With these values the whole 1 KiB target memory can be compared after every command, and both size limits can be reached on each side of the boundary with small rectangles. The bench sweeps every legal depth across several rectangle shapes and all four flag combinations. Memory acknowledges are stalled pseudo-randomly, which exercises the request-hold rule. Each rejection cause and both kinds of empty rectangle are also driven.

// File: rtl/rect_fill_pkg.sv
package rect_fill_pkg;

    localparam logic [7:0] LEN_EXPECT  = 8'd4;
    localparam logic [7:0] ROP_PAINT   = 8'hF0;
    localparam int         CMD_WORDS   = 6;
    localparam int         HDR_RGB_BIT = 20;
    localparam int         HDR_A_BIT   = 21;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_CHECK,
        ST_RUN
    } fill_state_t;

    typedef struct packed {
        logic [15:0] x1;
        logic [15:0] y1;
        logic [15:0] x2;
        logic [15:0] y2;
        logic [15:0] pitch;
        logic [31:0] base;
        logic [31:0] color;
        logic [1:0]  shift;
        logic        wr_rgb;
        logic        wr_alpha;
    } fill_cmd_t;

    function automatic logic depth_ok(input logic [1:0] code);
        return code != 2'd2;
    endfunction

    function automatic logic [1:0] depth_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/fill_cmd_decode.sv
module fill_cmd_decode
    import rect_fill_pkg::*;
#(
    parameter int ROW_LIMIT  = 32768,
    parameter int LINE_LIMIT = 65536
) (
    input  logic [CMD_WORDS-1:0][31:0] words,
    output fill_cmd_t                  cmd,
    output logic                       reject,
    output logic                       empty
);
    logic [31:0] row_bytes;
    logic [31:0] lines;
    logic        fmt_bad;
    logic        size_bad;

    always_comb begin
        cmd.wr_rgb   = words[0][HDR_RGB_BIT];
        cmd.wr_alpha = words[0][HDR_A_BIT];
        cmd.shift    = depth_shift(words[1][25:24]);
        cmd.pitch    = words[1][15:0];
        cmd.x1       = words[2][15:0];
        cmd.y1       = words[2][31:16];
        cmd.x2       = words[3][15:0];
        cmd.y2       = words[3][31:16];
        cmd.base     = words[4];
        cmd.color    = words[5];

        empty     = (cmd.x1 >= cmd.x2) || (cmd.y1 >= cmd.y2);
        row_bytes = 32'(cmd.x2 - cmd.x1) << cmd.shift;
        lines     = 32'(cmd.y2 - cmd.y1);

        fmt_bad  = (words[0][7:0] != LEN_EXPECT)
                 || (words[1][23:16] != ROP_PAINT)
                 || !depth_ok(words[1][25:24])
                 || (cmd.base[1:0] != 2'b00)
                 || (cmd.pitch[1:0] != 2'b00);
        size_bad = !empty && ((row_bytes >= 32'(ROW_LIMIT)) || (lines >= 32'(LINE_LIMIT)));
        reject   = fmt_bad || size_bad;
    end
endmodule

// File: rtl/fill_lane_pack.sv
module fill_lane_pack (
    input  logic [1:0]  shift,
    input  logic [1:0]  lane,
    input  logic [31:0] color,
    input  logic        wr_rgb,
    input  logic        wr_alpha,
    output logic [3:0]  be,
    output logic [31:0] wdata
);
    always_comb begin
        case (shift)
            2'd0: begin
                be    = 4'b0001 << lane;
                wdata = {4{color[7:0]}};
            end
            2'd1: begin
                be    = lane[1] ? 4'b1100 : 4'b0011;
                wdata = {2{color[15:0]}};
            end
            default: begin
                be    = {wr_alpha, {3{wr_rgb}}};
                wdata = color;
            end
        endcase
    end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rect_fill_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int ROW_LIMIT  = 32768,
    parameter int LINE_LIMIT = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = $clog2(CMD_WORDS);

    fill_state_t                state;
    logic [CNT_W-1:0]           wcnt;
    logic [CMD_WORDS-1:0][31:0] words;
    fill_cmd_t                  dec_cmd;
    fill_cmd_t                  cmd_q;
    logic                       dec_reject;
    logic                       dec_empty;
    logic [31:0]                row_addr;
    logic [31:0]                xoff;
    logic [31:0]                byte_addr;
    logic [15:0]                cur_x;
    logic [15:0]                cur_y;
    logic                       row_end;
    logic                       last_px;

    fill_cmd_decode #(.ROW_LIMIT(ROW_LIMIT), .LINE_LIMIT(LINE_LIMIT)) u_dec (
        .words  (words),
        .cmd    (dec_cmd),
        .reject (dec_reject),
        .empty  (dec_empty)
    );

    assign byte_addr = row_addr + xoff;

    fill_lane_pack u_pack (
        .shift    (cmd_q.shift),
        .lane     (byte_addr[1:0]),
        .color    (cmd_q.color),
        .wr_rgb   (cmd_q.wr_rgb),
        .wr_alpha (cmd_q.wr_alpha),
        .be       (mem_be),
        .wdata    (mem_wdata)
    );

    assign cmd_ready = (state == ST_COLLECT);
    assign busy      = (state != ST_COLLECT) || (wcnt != '0);
    assign mem_req   = (state == ST_RUN);
    assign mem_addr  = byte_addr[ADDR_W+1:2];
    assign row_end   = (cur_x + 16'd1) == cmd_q.x2;
    assign last_px   = row_end && ((cur_y + 16'd1) == cmd_q.y2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_COLLECT;
            wcnt     <= '0;
            words    <= '0;
            cmd_q    <= '0;
            row_addr <= '0;
            xoff     <= '0;
            cur_x    <= '0;
            cur_y    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_COLLECT: begin
                    if (cmd_valid) begin
                        words[wcnt] <= cmd_data;
                        if (wcnt == CNT_W'(CMD_WORDS - 1)) begin
                            wcnt  <= '0;
                            state <= ST_CHECK;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (dec_reject) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= ST_COLLECT;
                    end else if (dec_empty) begin
                        done  <= 1'b1;
                        state <= ST_COLLECT;
                    end else begin
                        cmd_q    <= dec_cmd;
                        row_addr <= dec_cmd.base + dec_cmd.y1 * dec_cmd.pitch;
                        xoff     <= 32'(dec_cmd.x1) << dec_cmd.shift;
                        cur_x    <= dec_cmd.x1;
                        cur_y    <= dec_cmd.y1;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (mem_ack) begin
                        if (last_px) begin
                            done  <= 1'b1;
                            state <= ST_COLLECT;
                        end else if (row_end) begin
                            cur_x    <= cmd_q.x1;
                            cur_y    <= cur_y + 16'd1;
                            row_addr <= row_addr + 32'(cmd_q.pitch);
                            xoff     <= 32'(cmd_q.x1) << cmd_q.shift;
                        end else begin
                            cur_x <= cur_x + 16'd1;
                            xoff  <= xoff + (32'd1 << cmd_q.shift);
                        end
                    end
                end
                default: state <= ST_COLLECT;
            endcase
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !busy));

    assert_req_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (busy && !cmd_ready));

    assert_reject_before_write_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(!mem_req));

    assert_single_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cmd_q.shift == 2'd0) |-> $onehot(mem_be));

endmodule

// File: tb/sim_rect_fill_engine.sv
`timescale 1ns/1ps
module sim_rect_fill_engine;
    localparam int AW    = 8;
    localparam int RLIM  = 64;
    localparam int LLIM  = 8;
    localparam int NBYTE = 4 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [31:0]   cmd_data = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_ack;
    logic          busy, done, err;

    logic [31:0] mem [1 << AW];
    logic [7:0]  expb [NBYTE];
    logic        stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          nwrites = 0;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    rect_fill_engine #(.ADDR_W(AW), .ROW_LIMIT(RLIM), .LINE_LIMIT(LLIM)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .busy(busy), .done(done), .err(err)
    );

    assign mem_ack = mem_req && !stall;

    always @(negedge clk) begin
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stall <= lfsr[0] & lfsr[3];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_ack) begin
            nwrites <= nwrites + 1;
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w, input bit first);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        if (first) check(busy == 1'b1, "R11 busy after header", int'(busy), 1);
    endtask

    task automatic run_cmd(input int len, input bit rgb, input bit alp, input int dcode,
                           input int rop, input int pitch, input int x1, input int y1,
                           input int x2, input int y2, input int base,
                           input logic [31:0] color, input bit exp_err, input string tag);
        int bpp, seen, mism, first_bad;
        logic [31:0] w [6];
        bit got_err, got_busy;
        bpp = (dcode == 3) ? 4 : dcode + 1;
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = {8'(i), 8'(i * 3), 8'(~i), 8'(i + 91)} ^ {lfsr, lfsr};
            for (int k = 0; k < 4; k++) expb[4*i + k] = mem[i][8*k +: 8];
        end
        if (!exp_err)
            for (int y = y1; y < y2; y++)
                for (int x = x1; x < x2; x++)
                    for (int k = 0; k < bpp; k++)
                        if (bpp < 4 || (k < 3 && rgb) || (k == 3 && alp))
                            expb[base + y*pitch + x*bpp + k] = color[8*k +: 8];
        w[0] = 32'(len) | (32'(rgb) << 20) | (32'(alp) << 21);
        w[1] = (32'(dcode) << 24) | (32'(rop & 255) << 16) | 32'(pitch & 16'hFFFF);
        w[2] = (32'(y1) << 16) | 32'(x1 & 16'hFFFF);
        w[3] = (32'(y2) << 16) | 32'(x2 & 16'hFFFF);
        w[4] = 32'(base);
        w[5] = color;
        nwrites = 0;
        for (int i = 0; i < 6; i++) send_word(w[i], i == 0);
        cmd_valid = 1'b0;
        seen = 0;
        for (int t = 0; t < 20000 && seen == 0; t++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check(seen == 1, {tag, " R11 done seen"}, seen, 1);
        got_err  = err;
        got_busy = busy;
        check(got_err == exp_err, {tag, " err flag"}, int'(got_err), int'(exp_err));
        check(got_busy == 1'b0, {tag, " R11 busy low at done"}, int'(got_busy), 0);
        @(negedge clk);
        check(done == 1'b0, {tag, " R11 done one cycle"}, int'(done), 0);
        if (exp_err || x1 >= x2 || y1 >= y2)
            check(nwrites == 0, {tag, " no writes"}, nwrites, 0);
        else
            check(nwrites == (x2-x1)*(y2-y1), {tag, " R2 one write per pixel"}, nwrites, (x2-x1)*(y2-y1));
        mism = 0;
        first_bad = -1;
        for (int b = 0; b < NBYTE; b++)
            if (mem[b/4][8*(b%4) +: 8] !== expb[b]) begin
                mism++;
                if (first_bad < 0) first_bad = b;
            end
        check(mism == 0, {tag, " R3 memory image, first bad byte index in actual"}, first_bad, -1);
    endtask

    int rx1 [4] = '{0, 3, 5, 1};
    int ry1 [4] = '{0, 1, 2, 0};
    int rx2 [4] = '{1, 10, 12, 16};
    int ry2 [4] = '{1, 4, 7, 3};
    int dcodes [3] = '{0, 1, 3};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && done == 0 && err == 0 && mem_req == 0 && cmd_ready == 1,
              "reset state R11", int'({busy, done, err, mem_req, cmd_ready}), 1);
        // R2 R3 R4 R5 R6: every legal depth over several rectangles and flag sets
        for (int d = 0; d < 3; d++)
            for (int r = 0; r < 4; r++)
                for (int f = 0; f < 4; f++)
                    if (dcodes[d] == 3 || f == r % 4)
                        run_cmd(4, f[0], f[1], dcodes[d], 'hF0, 128, rx1[r], ry1[r], rx2[r], ry2[r],
                                'h20, 32'hA1B2C3D4 + 32'(17*r + f), 1'b0, "R2 R4 R5 R6 sweep");
        // R7 boundaries
        run_cmd(4, 1, 1, 0, 'hF0, 64, 0, 0, 63, 1, 0, 32'h5A, 1'b0, "R7 row bytes 63 at 1B");
        run_cmd(4, 1, 1, 0, 'hF0, 64, 0, 0, 64, 1, 0, 32'h5A, 1'b1, "R7 row bytes 64 at 1B");
        run_cmd(4, 1, 1, 3, 'hF0, 64, 0, 0, 16, 1, 0, 32'h5A, 1'b1, "R7 row bytes 64 at 4B");
        run_cmd(4, 1, 1, 1, 'hF0, 64, 2, 0, 4, 8, 0, 32'h1234, 1'b1, "R7 eight lines");
        run_cmd(4, 1, 1, 1, 'hF0, 64, 2, 1, 4, 8, 0, 32'h1234, 1'b0, "R7 seven lines");
        // R8 R9 R4 R1 rejections
        run_cmd(4, 1, 1, 3, 'hCC, 64, 1, 1, 3, 3, 0, 32'h77, 1'b1, "R8 source copy");
        run_cmd(4, 1, 1, 3, 'h66, 64, 1, 1, 3, 3, 0, 32'h77, 1'b1, "R8 other rop");
        run_cmd(4, 1, 1, 3, 'hF0, 64, 1, 1, 3, 3, 'h22, 32'h77, 1'b1, "R9 base misaligned");
        run_cmd(4, 1, 1, 3, 'hF0, 66, 1, 1, 3, 3, 0, 32'h77, 1'b1, "R9 pitch misaligned");
        run_cmd(4, 1, 1, 2, 'hF0, 64, 1, 1, 3, 3, 0, 32'h77, 1'b1, "R4 depth code 2");
        run_cmd(5, 1, 1, 3, 'hF0, 64, 1, 1, 3, 3, 0, 32'h77, 1'b1, "R1 length field");
        // R10 empty rectangles, even past the size limits
        run_cmd(4, 1, 1, 3, 'hF0, 64, 4, 2, 4, 5, 0, 32'h99, 1'b0, "R10 zero width");
        run_cmd(4, 1, 1, 3, 'hF0, 64, 1, 5, 60, 3, 0, 32'h99, 1'b0, "R10 inverted y");
        run_cmd(4, 1, 1, 3, 'hCC, 64, 4, 2, 4, 5, 0, 32'h99, 1'b1, "R10 empty yet bad rop R8");
        finish_run();
    end
endmodule